// File: doc/BRIEF.md
# Integer ALU with shifter

A purely combinational arithmetic and logic unit for the execute stage of a small load/store processor. Each cycle it receives two register operands, a 16-bit immediate with its extension mode, a shift count and a 4-bit operation code. It returns one data-width result and an overflow flag. The flag is the only trap hint the unit gives, and the surrounding pipeline is expected to use it.

The second operand can come from the register port or from the immediate. The immediate is sign-extended for arithmetic use, or zero-extended when a logical OR must be able to load any value from 0 to 65535. The unit supports add and subtract in two forms: one that flags overflow and one that wraps silently. It also supports signed and unsigned less-than compares, four bitwise operations, three shifts whose count comes either from a constant field or from a register, and an upper-half immediate load. A single adder serves both addition and the two compares. The shifter is one logarithmic right-shift network, and left shifts reuse it through bit reversal.

Top module: `alu_core`

## Requirements
- R1: For op code 0 (add, flagging) and op code 2 (subtract, flagging), `ovf_o` is 1 exactly when the true signed result does not fit in DATA_W bits, and `result_o` holds the low DATA_W bits of the sum or difference (A minus B).
- R2: Op codes 1 (add, wrapping) and 3 (subtract, wrapping) produce the same result bits as codes 0 and 2, and `ovf_o` is 0 for every op code other than 0 and 2.
- R3: Op code 4 gives 1 when A is less than B as signed two's-complement values, and 0 otherwise. All upper bits of the result are zero.
- R4: Op code 5 gives 1 when A is less than B as unsigned values, and 0 otherwise. All upper bits of the result are zero.
- R5: Op codes 6, 7, 8 and 9 give the bitwise AND, OR, XOR and NOR of A and B. For example, the NOR of 0xFF00FF00 and 0xF0F0F0F0 is 0x000F000F.
- R6: Shifts act on operand B. When `shift_var_i` is 0, the count is `shamt_i`. When `shift_var_i` is 1, the count is the low 5 bits of A and the higher bits of A have no effect. A count of 0 returns B unchanged.
- R7: Op code 10 shifts left and fills the low bits with zeros. Op code 11 shifts right and fills with zeros. Op code 12 shifts right and fills with copies of B's top bit.
- R8: Op code 13 places the low 16 bits of operand B in bits 31..16 of the result and zeros in bits 15..0.
- R9: When `use_imm_i` is 1, operand B is `imm_i` extended to DATA_W bits. The extension copies `imm_i[15]` when `imm_zext_i` is 0 and fills with zeros when `imm_zext_i` is 1. When `use_imm_i` is 0, operand B is `opnd_b_i`.
- R10: Op codes 14 and 15 are unassigned. They return a result of 0 with `ovf_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see R1 to R10) |
| opnd_a_i | input | DATA_W | First register operand |
| opnd_b_i | input | DATA_W | Second register operand |
| imm_i | input | IMM_W | Immediate field |
| use_imm_i | input | 1 | Take operand B from the extended immediate |
| imm_zext_i | input | 1 | Zero-extend instead of sign-extend the immediate |
| shamt_i | input | log2(DATA_W) | Constant shift count |
| shift_var_i | input | 1 | Take the shift count from the low bits of A |
| result_o | output | DATA_W | Operation result |
| ovf_o | output | 1 | Signed overflow for the flagging add and subtract |

## Verification
The bench builds the unit with its defaults, DATA_W = 32 and IMM_W = 16. With these values the most-positive and most-negative boundaries, 0x7FFFFFFF + 1 and 0x80000000 - 1, can be driven directly. Shift counts of 0 and 31 cover the full 5-bit count range, and the 16-bit immediate sits exactly in the upper half of the word for the upper-load operation. Table vectors pin these corners. Several hundred random operand and op-code mixes are then compared against a behavioural model that uses wide signed arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD_TRAP = 4'd0,
        OP_ADD_WRAP = 4'd1,
        OP_SUB_TRAP = 4'd2,
        OP_SUB_WRAP = 4'd3,
        OP_LT_S     = 4'd4,
        OP_LT_U     = 4'd5,
        OP_AND      = 4'd6,
        OP_OR       = 4'd7,
        OP_XOR      = 4'd8,
        OP_NOR      = 4'd9,
        OP_SHL      = 4'd10,
        OP_SHR_L    = 4'd11,
        OP_SHR_A    = 4'd12,
        OP_UPPER    = 4'd13,
        OP_RSVD_E   = 4'd14,
        OP_RSVD_F   = 4'd15
    } alu_op_e;

    // Adder outputs shared by arithmetic and compares
    typedef struct packed {
        logic sum_msb_ovf;
        logic carry;
        logic lt_s;
        logic lt_u;
    } addsub_flags_t;

    function automatic logic op_is_trap(alu_op_e op);
        return (op == OP_ADD_TRAP) || (op == OP_SUB_TRAP);
    endfunction

    function automatic logic op_uses_sub(alu_op_e op);
        return (op == OP_SUB_TRAP) || (op == OP_SUB_WRAP) ||
               (op == OP_LT_S)     || (op == OP_LT_U);
    endfunction

    function automatic logic op_is_shift(alu_op_e op);
        return (op == OP_SHL) || (op == OP_SHR_L) || (op == OP_SHR_A);
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              zext,
    output logic [DATA_W-1:0] b_eff
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic              fill_bit;
    logic [DATA_W-1:0] imm_ext;

    assign fill_bit = zext ? 1'b0 : imm[IMM_W-1];
    assign imm_ext  = {{EXT_W{fill_bit}}, imm};
    assign b_eff    = use_imm ? imm_ext : reg_b;

    always_comb begin
        if (use_imm && zext) begin
            p_zext_upper_r9: assert (b_eff[DATA_W-1:IMM_W] == '0)
                else $error("zero-extended immediate has upper bits set");
        end
        if (use_imm) begin
            p_imm_low_r9: assert (b_eff[IMM_W-1:0] == imm)
                else $error("immediate low bits not passed through");
        end
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output addsub_flags_t     flags
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_inv;
    logic [DATA_W:0]   wide;
    logic              ovf_raw;

    assign b_inv = sub ? ~b : b;
    assign wide  = {1'b0, a} + {1'b0, b_inv} + {{DATA_W{1'b0}}, sub};
    assign sum   = wide[DATA_W-1:0];

    // Signed overflow: inputs agree in sign, result disagrees
    assign ovf_raw = (a[MSB] == b_inv[MSB]) && (sum[MSB] != a[MSB]);

    always_comb begin
        flags.sum_msb_ovf = ovf_raw;
        flags.carry       = wide[DATA_W];
        flags.lt_s        = sum[MSB] ^ ovf_raw;
        flags.lt_u        = ~wide[DATA_W];
    end

    always_comb begin
        if (ovf_raw && !sub) begin
            p_add_ovf_sign_r1: assert (a[MSB] == b[MSB])
                else $error("add overflow with operands of different sign");
        end
        if (sub && (a == b)) begin
            p_equal_not_less_r3: assert (!flags.lt_s && !flags.lt_u)
                else $error("equal operands compared as less");
        end
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] out
);
    logic [DATA_W-1:0] any_one;

    assign any_one = a | b;

    always_comb begin
        unique case (op)
            OP_AND:  out = a & b;
            OP_OR:   out = any_one;
            OP_XOR:  out = a ^ b;
            OP_NOR:  out = ~any_one;
            default: out = '0;
        endcase
    end

    always_comb begin
        if (op == OP_NOR) begin
            p_nor_disjoint_r5: assert ((out & (a | b)) == '0)
                else $error("NOR result overlaps an operand one");
        end
        if (op == OP_AND) begin
            p_and_subset_r5: assert ((out & ~a) == '0)
                else $error("AND result not a subset of A");
        end
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         din,
    input  logic [$clog2(DATA_W)-1:0] count,
    input  logic                      left,
    input  logic                      arith,
    output logic [DATA_W-1:0]         dout
);
    localparam int SH_W = $clog2(DATA_W);
    localparam int MSB  = DATA_W - 1;

    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] rev_out;
    logic [DATA_W-1:0] stage [SH_W+1];
    logic              fill;

    // Left shifts run through the right-shift network on reversed bits
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev_in[i]  = din[MSB-i];
        assign rev_out[i] = stage[SH_W][MSB-i];
    end

    assign fill     = arith & ~left & din[MSB];
    assign stage[0] = left ? rev_in : din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = count[k]
            ? {{STEP{fill}}, stage[k][DATA_W-1:STEP]}
            : stage[k];
    end

    assign dout = left ? rev_out : stage[SH_W];

    always_comb begin
        if (count == '0) begin
            p_zero_count_r6: assert (dout == din)
                else $error("shift by zero altered data");
        end
        if (arith && !left && din[MSB]) begin
            p_sign_fill_r7: assert (dout[MSB])
                else $error("arithmetic right shift lost sign");
        end
        if (left && count != '0) begin
            p_left_zero_r7: assert (!dout[0])
                else $error("left shift brought in a one");
        end
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [3:0]                op_i,
    input  logic [DATA_W-1:0]         opnd_a_i,
    input  logic [DATA_W-1:0]         opnd_b_i,
    input  logic [IMM_W-1:0]          imm_i,
    input  logic                      use_imm_i,
    input  logic                      imm_zext_i,
    input  logic [$clog2(DATA_W)-1:0] shamt_i,
    input  logic                      shift_var_i,
    output logic [DATA_W-1:0]         result_o,
    output logic                      ovf_o
);
    localparam int SH_W  = $clog2(DATA_W);
    localparam int LOW_W = DATA_W - IMM_W;

    alu_op_e           op;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;
    addsub_flags_t     flags;
    logic [DATA_W-1:0] bit_res;
    logic [DATA_W-1:0] sh_res;
    logic [SH_W-1:0]   sh_cnt;

    assign op     = alu_op_e'(op_i);
    assign sh_cnt = shift_var_i ? opnd_a_i[SH_W-1:0] : shamt_i;

    alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .reg_b   (opnd_b_i),
        .imm     (imm_i),
        .use_imm (use_imm_i),
        .zext    (imm_zext_i),
        .b_eff   (b_eff)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a     (opnd_a_i),
        .b     (b_eff),
        .sub   (op_uses_sub(op)),
        .sum   (sum),
        .flags (flags)
    );

    alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .a   (opnd_a_i),
        .b   (b_eff),
        .op  (op),
        .out (bit_res)
    );

    alu_shifter #(.DATA_W(DATA_W)) u_shift (
        .din   (b_eff),
        .count (sh_cnt),
        .left  (op == OP_SHL),
        .arith (op == OP_SHR_A),
        .dout  (sh_res)
    );

    always_comb begin
        result_o = '0;
        unique case (op)
            OP_ADD_TRAP, OP_ADD_WRAP,
            OP_SUB_TRAP, OP_SUB_WRAP:       result_o = sum;
            OP_LT_S:                        result_o = {{(DATA_W-1){1'b0}}, flags.lt_s};
            OP_LT_U:                        result_o = {{(DATA_W-1){1'b0}}, flags.lt_u};
            OP_AND, OP_OR, OP_XOR, OP_NOR:  result_o = bit_res;
            OP_SHL, OP_SHR_L, OP_SHR_A:     result_o = sh_res;
            OP_UPPER:                       result_o = {b_eff[IMM_W-1:0], {LOW_W{1'b0}}};
            default:                        result_o = '0;
        endcase
    end

    assign ovf_o = op_is_trap(op) & flags.sum_msb_ovf;

    always_comb begin
        if (ovf_o) begin
            p_no_overflow_r2: assert (op_i == 4'd0 || op_i == 4'd2)
                else $error("overflow flagged on non-trapping op");
        end
        if (op == OP_LT_S || op == OP_LT_U) begin
            p_compare_01_r4: assert (result_o[DATA_W-1:1] == '0)
                else $error("compare result wider than one bit");
        end
        if (op == OP_UPPER) begin
            p_upper_low_zero_r8: assert (result_o[LOW_W-1:0] == '0)
                else $error("upper load left low bits set");
        end
        if (op_i == 4'd14 || op_i == 4'd15) begin
            p_rsvd_zero_r10: assert (result_o == '0 && !ovf_o)
                else $error("reserved op produced output");
        end
    end
endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  sh;
        logic [31:0] res;
        logic        ovf;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b1}, // R1
        '{4'd1,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b0}, // R2
        '{4'd2,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b1}, // R1
        '{4'd3,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b0}, // R2
        '{4'd4,  32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000001, 1'b0}, // R3
        '{4'd5,  32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 1'b0}, // R4
        '{4'd9,  32'hFF00FF00, 32'hF0F0F0F0, 5'd0,  32'h000F000F, 1'b0}, // R5
        '{4'd8,  32'hFF00FF00, 32'hF0F0F0F0, 5'd0,  32'h0FF00FF0, 1'b0}, // R5
        '{4'd12, 32'h00000000, 32'h80000000, 5'd31, 32'hFFFFFFFF, 1'b0}, // R7
        '{4'd11, 32'h00000000, 32'h80000000, 5'd31, 32'h00000001, 1'b0}, // R7
        '{4'd10, 32'h00000000, 32'h00000001, 5'd31, 32'h80000000, 1'b0}, // R7
        '{4'd10, 32'h00000000, 32'h12345678, 5'd0,  32'h12345678, 1'b0}, // R6
        '{4'd13, 32'h00000000, 32'h0000C0DE, 5'd0,  32'hC0DE0000, 1'b0}, // R8
        '{4'd14, 32'h00000001, 32'h00000001, 5'd0,  32'h00000000, 1'b0}, // R10
        '{4'd0,  32'h80000000, 32'h80000000, 5'd0,  32'h00000000, 1'b1}, // R1
        '{4'd2,  32'h00000000, 32'h80000000, 5'd0,  32'h80000000, 1'b1}  // R1
    };
    localparam string VTAG [NVEC] = '{
        "R1", "R2", "R1", "R2", "R3", "R4", "R5", "R5",
        "R7", "R7", "R7", "R6", "R8", "R10", "R1", "R1"
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [3:0]        op;
    logic [DATA_W-1:0] a, b;
    logic [IMM_W-1:0]  imm;
    logic              use_imm, zext, shvar;
    logic [4:0]        shamt;
    logic [DATA_W-1:0] res;
    logic              ovf;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    alu_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) dut (
        .op_i        (op),
        .opnd_a_i    (a),
        .opnd_b_i    (b),
        .imm_i       (imm),
        .use_imm_i   (use_imm),
        .imm_zext_i  (zext),
        .shamt_i     (shamt),
        .shift_var_i (shvar),
        .result_o    (res),
        .ovf_o       (ovf)
    );

    // Behavioural reference for register-operand mode
    function automatic logic [32:0] model(logic [3:0] o, logic [31:0] x,
                                          logic [31:0] y, logic [4:0] s);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint w;
        logic   f = 1'b0;
        logic [31:0] r = '0;
        case (o)
            4'd0, 4'd1: begin w = sx + sy; r = x + y; f = (o == 4'd0) && (w > 64'sd2147483647 || w < -64'sd2147483648); end
            4'd2, 4'd3: begin w = sx - sy; r = x - y; f = (o == 4'd2) && (w > 64'sd2147483647 || w < -64'sd2147483648); end
            4'd4:  r = (sx < sy) ? 32'd1 : 32'd0;
            4'd5:  r = (x < y) ? 32'd1 : 32'd0;
            4'd6:  r = x & y;
            4'd7:  r = x | y;
            4'd8:  r = x ^ y;
            4'd9:  r = ~(x | y);
            4'd10: r = y << s;
            4'd11: r = y >> s;
            4'd12: r = 32'($signed(y) >>> s);
            4'd13: r = {y[15:0], 16'h0000};
            default: r = '0;
        endcase
        return {f, r};
    endfunction

    function automatic string op_tag(logic [3:0] o);
        case (o)
            4'd0, 4'd2: return "R1";
            4'd1, 4'd3: return "R2";
            4'd4: return "R3";
            4'd5: return "R4";
            4'd6, 4'd7, 4'd8, 4'd9: return "R5";
            4'd10, 4'd11, 4'd12: return "R7";
            4'd13: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic drive(logic [3:0] o, logic [31:0] x, logic [31:0] y,
                         logic [4:0] s, logic sv, logic ui, logic zx,
                         logic [15:0] im);
        @(negedge clk);
        op = o; a = x; b = y; shamt = s; shvar = sv;
        use_imm = ui; zext = zx; imm = im;
        #5;
    endtask

    task automatic check(string tag, logic [31:0] er, logic eo);
        checks++;
        if (res !== er || ovf !== eo) begin
            failures++;
            $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                     tag, res, ovf, er, eo);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [32:0] exp;
        op = '0; a = '0; b = '0; shamt = '0; shvar = 1'b0;
        use_imm = 1'b0; zext = 1'b0; imm = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle inputs: zero add gives zero without overflow (R2)
        drive(4'd0, 32'h0, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R2 idle", 32'h0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].sh,
                  1'b0, 1'b0, 1'b0, 16'h0);
            check(VTAG[i], VECS[i].res, VECS[i].ovf);
        end

        // R6: variable count uses A[4:0]=4, upper bits of A ignored
        drive(4'd10, 32'hFFFFFFE4, 32'h00000010, 5'd17, 1'b1, 1'b0, 1'b0, 16'h0);
        check("R6 var shl", 32'h00000100, 1'b0);
        drive(4'd12, 32'h0000001F, 32'h40000000, 5'd2, 1'b1, 1'b0, 1'b0, 16'h0);
        check("R6 var sra 31", 32'h00000000, 1'b0);

        // R9: immediate sign and zero extension
        drive(4'd1, 32'h0, 32'h12345678, 5'd0, 1'b0, 1'b1, 1'b0, 16'hFFD6);
        check("R9 sext", 32'hFFFFFFD6, 1'b0);
        drive(4'd7, 32'h0, 32'h12345678, 5'd0, 1'b0, 1'b1, 1'b1, 16'hFFD6);
        check("R9 zext", 32'h0000FFD6, 1'b0);
        drive(4'd13, 32'h0, 32'h0, 5'd0, 1'b0, 1'b1, 1'b1, 16'hC0DE);
        check("R8 imm upper", 32'hC0DE0000, 1'b0);
        drive(4'd0, 32'h7FFFFFFF, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0, 16'h0001);
        check("R1 imm ovf", 32'h80000000, 1'b1);

        // R10: op code 15 with operands that would overflow an add
        drive(4'd15, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd3, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R10 op15", 32'h0, 1'b0);

        // Random mix against the model
        for (int n = 0; n < 400; n++) begin
            logic [3:0]  ro = 4'($urandom_range(0, 15));
            logic [31:0] ra = $urandom;
            logic [31:0] rb = $urandom;
            logic [4:0]  rs = 5'($urandom);
            logic        rv = 1'($urandom);
            if (n % 8 == 0) ra = 32'h80000000;
            if (n % 8 == 1) rb = 32'h7FFFFFFF;
            drive(ro, ra, rb, rs, rv, 1'b0, 1'b0, 16'h0);
            exp = model(ro, ra, rb, rv ? ra[4:0] : rs);
            check(op_tag(ro), exp[31:0], exp[32]);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule